// File: doc/BRIEF.md
# Floating-point register file with NaN boxing

This block holds the floating-point architectural registers of a core: 32 entries, each `FLEN` bits wide, where `FLEN` is 32 or 64. One write port and two read ports each carry a precision code. A value narrower than the register is padded with ones on the way in. On the way out, a narrow value is accepted only if that padding is intact. If the padding is damaged, the read returns the canonical quiet NaN of the requested precision.

Every accepted write marks the floating-point context as modified. The block drives a two-bit context state, which goes to the dirty code, and a one-bit summary flag. A precision code that the configured width cannot hold is reported on a per-port illegal flag, and a write that carries such a code is dropped. Reads are combinational, and a write lands on the clock edge.

Top module: `fp_boxed_regfile`

## Requirements
- R1: A half-precision write (precision code 0) stores bits 15..0 of the write data and sets every register bit above bit 15 to one. Any higher write-data bits are discarded.
- R2: A single-precision write (code 1) stores bits 31..0 of the write data. With FLEN=64, bits 63..32 of the register are set to one. With FLEN=32, the value is stored as is.
- R3: A half-precision read returns register bits 15..0 in result bits 15..0 when all register bits above 15 are one. Otherwise it returns 0x7E00. In both cases the result bits above 15 are zero.
- R4: A single-precision read with FLEN=64 returns register bits 31..0 when bits 63..32 are all one, and returns 0x7FC00000 otherwise. The result bits above 31 are zero.
- R5: A double-precision access (code 2, FLEN=64 only) writes and reads all 64 bits unmodified.
- R6: Every accepted write moves the context state output to 2'b11 (dirty) and raises the summary dirty flag. Both stay set until reset.
- R7: After reset, all 32 registers hold zero, the context state is 2'b00, and the summary flag is low.
- R8: Registers are addressed by a 5-bit index 0..31, and register 0 stores data like any other register. The two read ports are independent. A read in the same cycle as a write to the same index returns the value held before the write.
- R9: Precision code 3, and code 2 when FLEN=32, are illegal. A port given an illegal code raises its illegal flag (for the write port, only while the write enable is high). An illegal write changes no register and does not set the dirty state, and an illegal read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_prec | input | 2 | Write precision: 0 half, 1 single, 2 double, 3 reserved |
| wr_data | input | FLEN | Write value, right-aligned |
| wr_illegal | output | 1 | Write request carries an unsupported precision |
| rda_idx | input | 5 | Read port A index |
| rda_prec | input | 2 | Read port A precision |
| rda_data | output | FLEN | Read port A result, unboxed and zero-extended |
| rda_illegal | output | 1 | Port A precision unsupported |
| rdb_idx | input | 5 | Read port B index |
| rdb_prec | input | 2 | Read port B precision |
| rdb_data | output | FLEN | Read port B result, unboxed and zero-extended |
| rdb_illegal | output | 1 | Port B precision unsupported |
| ctx_state | output | 2 | Floating-point context state, 2'b11 once dirty |
| ctx_dirty | output | 1 | Summary dirty flag |

## Verification
The assertions assume the precision inputs are known whenever a port is in use and that reset is held for at least one edge. They also assume the single write port is the only thing that can change the context state. The stimulus keeps to this by driving every input at the falling edge with defined values. It parks the write enable low between operations and issues the illegal-code write before any legal write, so a clean context can be observed staying clean.

// File: rtl/fp_boxed_regfile.sv
module fp_boxed_regfile #(
  parameter int FLEN = 64,
  parameter int NREG = 32,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [1:0]      wr_prec,
  input  logic [FLEN-1:0] wr_data,
  output logic            wr_illegal,
  input  logic [IDXW-1:0] rda_idx,
  input  logic [1:0]      rda_prec,
  output logic [FLEN-1:0] rda_data,
  output logic            rda_illegal,
  input  logic [IDXW-1:0] rdb_idx,
  input  logic [1:0]      rdb_prec,
  output logic [FLEN-1:0] rdb_data,
  output logic            rdb_illegal,
  output logic [1:0]      ctx_state,
  output logic            ctx_dirty
);

  localparam logic [1:0] P_HALF   = 2'd0;
  localparam logic [1:0] P_SINGLE = 2'd1;
  localparam logic [1:0] P_DOUBLE = 2'd2;

  localparam logic [FLEN-1:0] KEEP_H  = FLEN'(32'h0000_FFFF);
  localparam logic [FLEN-1:0] KEEP_S  = FLEN'(32'hFFFF_FFFF);
  localparam logic [FLEN-1:0] QNAN_H  = FLEN'(32'h0000_7E00);
  localparam logic [FLEN-1:0] QNAN_S  = FLEN'(32'h7FC0_0000);

  logic [FLEN-1:0] regs [NREG];
  logic [FLEN-1:0] boxed;
  logic            wr_go;

  function automatic logic bad_prec(input logic [1:0] p);
    return (p == 2'd3) || (p == P_DOUBLE && FLEN < 64);
  endfunction

  function automatic logic [FLEN-1:0] unbox(input logic [FLEN-1:0] v, input logic [1:0] p);
    if (bad_prec(p))   return '0;
    if (p == P_HALF)   return (&(v | KEEP_H)) ? (v & KEEP_H) : QNAN_H;
    if (p == P_SINGLE) return (&(v | KEEP_S)) ? (v & KEEP_S) : QNAN_S;
    return v;
  endfunction

  always_comb begin
    unique case (wr_prec)
      P_HALF:   boxed = (wr_data & KEEP_H) | ~KEEP_H;
      P_SINGLE: boxed = (wr_data & KEEP_S) | ~KEEP_S;
      default:  boxed = wr_data;
    endcase
  end

  assign wr_illegal  = wr_en && bad_prec(wr_prec);
  assign wr_go       = wr_en && !bad_prec(wr_prec);
  assign rda_illegal = bad_prec(rda_prec);
  assign rdb_illegal = bad_prec(rdb_prec);
  assign rda_data    = unbox(regs[rda_idx], rda_prec);
  assign rdb_data    = unbox(regs[rdb_idx], rdb_prec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_go) begin
      regs[wr_idx] <= boxed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_state <= 2'b00;
      ctx_dirty <= 1'b0;
    end else if (wr_go) begin
      ctx_state <= 2'b11;
      ctx_dirty <= 1'b1;
    end
  end

  p_write_marks_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_illegal) |=> (ctx_state == 2'b11 && ctx_dirty));

  p_dirty_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_dirty |=> ctx_dirty);

  p_illegal_write_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_illegal && !ctx_dirty) |=> !ctx_dirty);

  p_half_read_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_prec == P_HALF) |-> ((rda_data & ~KEEP_H) == '0));

  p_single_read_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdb_prec == P_SINGLE) |-> ((rdb_data & ~KEEP_S) == '0));

  p_illegal_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rda_illegal |-> (rda_data == '0));

endmodule

// File: tb/tb_fp_boxed_regfile.sv
module tb_fp_boxed_regfile;
  localparam int FLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [4:0]      wr_idx = '0;
  logic [1:0]      wr_prec = '0;
  logic [FLEN-1:0] wr_data = '0;
  logic            wr_illegal;
  logic [4:0]      rda_idx = '0;
  logic [1:0]      rda_prec = 2'd2;
  logic [FLEN-1:0] rda_data;
  logic            rda_illegal;
  logic [4:0]      rdb_idx = '0;
  logic [1:0]      rdb_prec = 2'd2;
  logic [FLEN-1:0] rdb_data;
  logic            rdb_illegal;
  logic [1:0]      ctx_state;
  logic            ctx_dirty;

  int applied = 0;
  int bad = 0;

  always #10 clk = ~clk;

  fp_boxed_regfile #(.FLEN(FLEN)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_prec(wr_prec), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .rda_idx(rda_idx), .rda_prec(rda_prec), .rda_data(rda_data), .rda_illegal(rda_illegal),
    .rdb_idx(rdb_idx), .rdb_prec(rdb_prec), .rdb_data(rdb_data), .rdb_illegal(rdb_illegal),
    .ctx_state(ctx_state), .ctx_dirty(ctx_dirty)
  );

  // {write prec, index, write data, read prec, expected read}
  localparam int NV = 12;
  localparam logic [136:0] VEC [NV] = '{
    {2'd0, 5'd1,  64'h0000_0000_0000_1234, 2'd0, 64'h0000_0000_0000_1234}, // R1 R3
    {2'd0, 5'd2,  64'h0000_0000_0000_ABCD, 2'd1, 64'h0000_0000_FFFF_ABCD}, // R1 R4
    {2'd0, 5'd3,  64'h0000_0000_0000_5555, 2'd2, 64'hFFFF_FFFF_FFFF_5555}, // R1 R5
    {2'd1, 5'd4,  64'h0000_0000_3F80_0000, 2'd1, 64'h0000_0000_3F80_0000}, // R2 R4
    {2'd1, 5'd5,  64'h0000_0000_4049_0FDB, 2'd0, 64'h0000_0000_0000_7E00}, // R2 R3
    {2'd1, 5'd6,  64'h0000_0000_FFFF_1111, 2'd0, 64'h0000_0000_0000_1111}, // R2 R3
    {2'd2, 5'd7,  64'h4009_21FB_5444_2D18, 2'd2, 64'h4009_21FB_5444_2D18}, // R5
    {2'd2, 5'd8,  64'h4009_21FB_5444_2D18, 2'd1, 64'h0000_0000_7FC0_0000}, // R4
    {2'd2, 5'd9,  64'hFFFF_FFFF_1234_5678, 2'd1, 64'h0000_0000_1234_5678}, // R4
    {2'd2, 5'd10, 64'h0000_0000_0000_0000, 2'd0, 64'h0000_0000_0000_7E00}, // R3
    {2'd2, 5'd0,  64'hDEAD_BEEF_CAFE_F00D, 2'd2, 64'hDEAD_BEEF_CAFE_F00D}, // R8
    {2'd1, 5'd31, 64'hAAAA_AAAA_0BAD_F00D, 2'd2, 64'hFFFF_FFFF_0BAD_F00D}  // R2
  };

  task automatic check(input string req, input logic [FLEN-1:0] act, input logic [FLEN-1:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] p, input logic [4:0] i, input logic [FLEN-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_prec = p; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 state", FLEN'(ctx_state), '0);
    check("R7 dirty", FLEN'(ctx_dirty), '0);
    rda_idx = 5'd17; rda_prec = 2'd2; rdb_idx = 5'd0; rdb_prec = 2'd0; #1;
    check("R7 reg17 zero", rda_data, '0);
    check("R7 R3 zero reg half read", rdb_data, 64'h7E00);

    // R9: illegal write before any legal one
    @(negedge clk);
    wr_en = 1'b1; wr_prec = 2'd3; wr_idx = 5'd12; wr_data = 64'h1111; #1;
    check("R9 wr_illegal", FLEN'(wr_illegal), 1);
    @(negedge clk);
    wr_en = 1'b0; #1;
    check("R9 wr_illegal low when idle", FLEN'(wr_illegal), 0);
    check("R9 no dirty", FLEN'(ctx_dirty), 0);
    check("R9 state clean", FLEN'(ctx_state), 0);
    rda_idx = 5'd12; rda_prec = 2'd2; #1;
    check("R9 reg unchanged", rda_data, '0);
    rdb_idx = 5'd12; rdb_prec = 2'd3; #1;
    check("R9 rd illegal flag", FLEN'(rdb_illegal), 1);
    check("R9 rd illegal zero", rdb_data, '0);

    for (int k = 0; k < NV; k++) begin
      do_write(VEC[k][136:135], VEC[k][134:130], VEC[k][129:66]);
      rda_idx = VEC[k][134:130]; rda_prec = VEC[k][65:64];
      rdb_idx = VEC[k][134:130]; rdb_prec = VEC[k][65:64];
      #1;
      check($sformatf("R1-5 vec%0d port A", k), rda_data, VEC[k][63:0]);
      check($sformatf("R8 vec%0d port B", k), rdb_data, VEC[k][63:0]);
      if (k == 0) begin
        check("R6 state", FLEN'(ctx_state), 2'b11);
        check("R6 dirty", FLEN'(ctx_dirty), 1);
      end
    end

    // R8: independent ports
    rda_idx = 5'd7; rda_prec = 2'd2; rdb_idx = 5'd9; rdb_prec = 2'd2; #1;
    check("R8 port A idx7", rda_data, 64'h4009_21FB_5444_2D18);
    check("R8 port B idx9", rdb_data, 64'hFFFF_FFFF_1234_5678);

    // R8: same-cycle write/read returns old value
    @(negedge clk);
    wr_en = 1'b1; wr_prec = 2'd2; wr_idx = 5'd1; wr_data = 64'h0123_4567_89AB_CDEF;
    rda_idx = 5'd1; rda_prec = 2'd2; #1;
    check("R8 no forwarding", rda_data, 64'hFFFF_FFFF_FFFF_1234);
    @(negedge clk);
    wr_en = 1'b0; #1;
    check("R8 new value after edge", rda_data, 64'h0123_4567_89AB_CDEF);

    // R1: half write discards high data bits
    do_write(2'd0, 5'd20, 64'h1234_5678_9ABC_DEF0);
    rda_idx = 5'd20; rda_prec = 2'd2; #1;
    check("R1 high data discarded", rda_data, 64'hFFFF_FFFF_FFFF_DEF0);

    // R6: dirty sticky after idle cycles
    repeat (3) @(negedge clk);
    #1;
    check("R6 sticky", FLEN'(ctx_dirty), 1);

    // R7: reset clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rda_idx = 5'd7; rda_prec = 2'd2; #1;
    check("R7 reset clears reg", rda_data, '0);
    check("R7 reset clears dirty", FLEN'(ctx_dirty), 0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule